// File: doc/BRIEF.md
# Per-Core Hardware Mutex Bank

This block holds a small set of hardware locks that several processor cores share. Each lock sits at its own word address in the device register window. A core that wants a lock writes a 1 to that address. A core that is done with a lock writes a 0 to it. A core that wants to know whether it holds a lock reads the address.

Every lock stores an occupied bit and the ID of the core that owns it. Only the owner can free a lock. A read answers for the reading core alone: it returns 1 when that core owns the lock and 0 in every other case. No core can see whether some other core holds the lock.

Each core drives its own request slot on every clock cycle. When several cores reach for the same free lock in one cycle, the core with the lowest ID gets it. The read answer comes back registered, one cycle after the request.

Top module: `mutex_bank`

## Requirements
- R1: After synchronous reset every lock is free, every `rd_vld` bit is 0, and a read of any lock by any core returns 0.
- R2: A write with `req_wdata` = 1 to a free lock makes the writing core its owner. A read of that lock then returns 1 to the owner and 0 to every other core.
- R3: A write of 1 to a lock that is already held changes neither its state nor its owner. This holds when a different core writes, and it also holds when the owner writes.
- R4: A write with `req_wdata` = 0 from the owning core frees the lock, and any core can then acquire it.
- R5: A write of 0 from a core that does not own the lock is ignored. The owner keeps the lock.
- R6: When several cores write 1 to the same free lock in the same cycle, the core with the lowest ID becomes the owner and the other writes have no effect.
- R7: A write of 1 succeeds only when the lock is free at the start of the cycle. If the owner frees a lock in the same cycle that another core writes 1 to it, the lock ends up free.
- R8: A read request (`req_vld` = 1, `req_we` = 0) raises that core's `rd_vld` in the following cycle, with the status in `rd_data`. In a cycle that follows no read request from a core, that core's `rd_vld` stays 0.
- R9: Lock k sits at word address 0xFC00 + k, for k from 0 to 7. Writes to addresses outside this range are ignored, and reads of those addresses return 0.
- R10: The locks are independent of each other. Acquiring or freeing one lock leaves every other lock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NUM_CORES | Per-core request valid |
| req_we | input | NUM_CORES | Per-core write enable (1 = write, 0 = read) |
| req_addr | input | NUM_CORES*ADDR_W | Per-core word address; core c uses bits [c*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_CORES | Per-core write value (1 = acquire, 0 = release) |
| rd_vld | output | NUM_CORES | Per-core read response valid, registered |
| rd_data | output | NUM_CORES | Per-core ownership status for the lock that was read, registered |

## Verification
The bench uses the default parameters: four cores, eight locks, and a base address of 0xFC00. With four cores, all of them can contend for one lock in a single cycle, which shows that core 0 wins over the other three. It also allows a cycle in which the owner frees a lock while a different core tries to take it. With eight locks, the bench can reach both edges of the window: the last lock at 0xFC07, the address 0xFC08 just above it, and 0xFBFF just below it. The bench checks 0xFC08 against lock 0 to catch an address that wraps around.

// File: rtl/mutex_bank_pkg.sv
package mutex_bank_pkg;

  typedef enum logic {
    MX_RELEASE = 1'b0,
    MX_ACQUIRE = 1'b1
  } mx_op_e;

  localparam int MX_DEF_CORES = 4;
  localparam int MX_DEF_LOCKS = 8;
  localparam int MX_DEF_ADDR_W = 16;

endpackage

// File: rtl/mutex_decode.sv
// Per-core address decode: turns one request slot into per-lock
// acquire/release strobes and a read index.
module mutex_decode
  import mutex_bank_pkg::*;
#(
  parameter int ADDR_W = MX_DEF_ADDR_W,
  parameter int NUM_MUTEX = MX_DEF_LOCKS,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFC00,
  localparam int IW = (NUM_MUTEX > 1) ? $clog2(NUM_MUTEX) : 1
) (
  input  logic              vld,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata,
  output logic [NUM_MUTEX-1:0] acq_sel,
  output logic [NUM_MUTEX-1:0] rel_sel,
  output logic              rd_hit,
  output logic [IW-1:0]     rd_idx
);

  logic [ADDR_W-1:0] offset;
  logic              in_win;
  logic              is_wr;

  assign offset = addr - BASE_ADDR;
  assign in_win = (addr >= BASE_ADDR) && (offset < ADDR_W'(NUM_MUTEX));
  assign is_wr  = vld && we && in_win;
  assign rd_hit = vld && !we && in_win;
  assign rd_idx = offset[IW-1:0];

  for (genvar m = 0; m < NUM_MUTEX; m++) begin : g_lock
    logic match;
    assign match      = is_wr && (offset == ADDR_W'(m));
    assign acq_sel[m] = match && (wdata == MX_ACQUIRE);
    assign rel_sel[m] = match && (wdata == MX_RELEASE);
  end

endmodule

// File: rtl/mutex_cell.sv
// One lock: occupied bit, owner ID, lowest-ID arbitration.
module mutex_cell #(
  parameter int NUM_CORES = 4,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CORES-1:0] acq_req,
  input  logic [NUM_CORES-1:0] rel_req,
  output logic [NUM_CORES-1:0] own_vec
);

  logic          held_q, held_d;
  logic [CW-1:0] owner_q, owner_d;
  logic [CW-1:0] win;

  // lowest set request index
  always_comb begin
    win = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (acq_req[c]) win = CW'(c);
    end
  end

  always_comb begin
    held_d  = held_q;
    owner_d = owner_q;
    if (!held_q) begin
      if (|acq_req) begin
        held_d  = 1'b1;
        owner_d = win;
      end
    end else if (rel_req[owner_q]) begin
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else begin
      held_q  <= held_d;
      owner_q <= owner_d;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_own
    assign own_vec[c] = held_q && (owner_q == CW'(c));
  end

  p_take_free_r2: assert property (@(posedge clk) disable iff (rst)
    (!held_q && |acq_req) |=> held_q);

  p_keep_owner_r3: assert property (@(posedge clk) disable iff (rst)
    (held_q && !rel_req[owner_q]) |=> (held_q && $stable(owner_q)));

  p_owner_frees_r4: assert property (@(posedge clk) disable iff (rst)
    (held_q && rel_req[owner_q]) |=> !held_q);

  p_core0_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (!held_q && acq_req[0]) |=> own_vec[0]);

  p_idle_stays_free_r10: assert property (@(posedge clk) disable iff (rst)
    (!held_q && (acq_req == '0)) |=> !held_q);

endmodule

// File: rtl/mutex_bank.sv
// Bank of per-core-owned hardware locks in the device register window.
module mutex_bank
  import mutex_bank_pkg::*;
#(
  parameter int NUM_CORES = MX_DEF_CORES,
  parameter int NUM_MUTEX = MX_DEF_LOCKS,
  parameter int ADDR_W = MX_DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFC00
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CORES-1:0]        req_vld,
  input  logic [NUM_CORES-1:0]        req_we,
  input  logic [NUM_CORES*ADDR_W-1:0] req_addr,
  input  logic [NUM_CORES-1:0]        req_wdata,
  output logic [NUM_CORES-1:0]        rd_vld,
  output logic [NUM_CORES-1:0]        rd_data
);

  localparam int IW = (NUM_MUTEX > 1) ? $clog2(NUM_MUTEX) : 1;

  logic [NUM_MUTEX-1:0] acq_by_core [NUM_CORES];
  logic [NUM_MUTEX-1:0] rel_by_core [NUM_CORES];
  logic [NUM_CORES-1:0] acq_by_lock [NUM_MUTEX];
  logic [NUM_CORES-1:0] rel_by_lock [NUM_MUTEX];
  logic [NUM_CORES-1:0] own_by_lock [NUM_MUTEX];
  logic [NUM_CORES-1:0] rd_hit;
  logic [IW-1:0]        rd_idx [NUM_CORES];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    mutex_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_MUTEX(NUM_MUTEX),
      .BASE_ADDR(BASE_ADDR)
    ) u_dec (
      .vld    (req_vld[c]),
      .we     (req_we[c]),
      .addr   (req_addr[c*ADDR_W +: ADDR_W]),
      .wdata  (req_wdata[c]),
      .acq_sel(acq_by_core[c]),
      .rel_sel(rel_by_core[c]),
      .rd_hit (rd_hit[c]),
      .rd_idx (rd_idx[c])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_vld[c]  <= 1'b0;
        rd_data[c] <= 1'b0;
      end else begin
        rd_vld[c]  <= req_vld[c] && !req_we[c];
        rd_data[c] <= rd_hit[c] && own_by_lock[rd_idx[c]][c];
      end
    end

    p_rd_resp_r8: assert property (@(posedge clk) disable iff (rst)
      (req_vld[c] && !req_we[c]) |=> rd_vld[c]);

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
      !(req_vld[c] && !req_we[c]) |=> !rd_vld[c]);

    p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (req_vld[c] && !req_we[c] && !rd_hit[c]) |=> !rd_data[c]);
  end

  for (genvar m = 0; m < NUM_MUTEX; m++) begin : g_lock
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_xpose
      assign acq_by_lock[m][c] = acq_by_core[c][m];
      assign rel_by_lock[m][c] = rel_by_core[c][m];
    end

    mutex_cell #(
      .NUM_CORES(NUM_CORES)
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .acq_req(acq_by_lock[m]),
      .rel_req(rel_by_lock[m]),
      .own_vec(own_by_lock[m])
    );
  end

endmodule

// File: tb/mutex_bank_bench.sv
`timescale 1ns/1ps
module mutex_bank_bench;

  localparam int NC = 4;
  localparam int NM = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] req_vld = '0;
  logic [NC-1:0] req_we = '0;
  logic [NC*AW-1:0] req_addr = '0;
  logic [NC-1:0] req_wdata = '0;
  logic [NC-1:0] rd_vld;
  logic [NC-1:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int    q_core [$];
  logic  q_exp  [$];
  string q_tag  [$];

  always #5 clk = ~clk;

  mutex_bank #(.NUM_CORES(NC), .NUM_MUTEX(NM), .ADDR_W(AW)) u_mutex_bank (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  function automatic logic [AW-1:0] mx(int k);
    return 16'hFC00 + AW'(k);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_wr(int c, logic [AW-1:0] a, logic d);
    req_vld[c] = 1'b1;
    req_we[c] = 1'b1;
    req_addr[c*AW +: AW] = a;
    req_wdata[c] = d;
  endtask

  // reads within one cycle must be issued in ascending core order
  task automatic put_rd(int c, logic [AW-1:0] a, logic e, string tag);
    req_vld[c] = 1'b1;
    req_we[c] = 1'b0;
    req_addr[c*AW +: AW] = a;
    q_core.push_back(c);
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic step();
    @(negedge clk);
    req_vld = '0;
    req_we = '0;
    req_addr = '0;
    req_wdata = '0;
  endtask

  // monitor: pops expected read results as responses appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int c = 0; c < NC; c++) begin
        if (rd_vld[c]) begin
          if (q_core.size() == 0) begin
            check(1'b0, "R8 unexpected response", c, -1);
          end else begin
            int    ec;
            logic  ee;
            string et;
            ec = q_core.pop_front();
            ee = q_exp.pop_front();
            et = q_tag.pop_front();
            total++;
            if (ec != c || rd_data[c] !== ee) begin
              bad++;
              $display("FAIL %s core=%0d data=%b expected core=%0d data=%b",
                       et, c, rd_data[c], ec, ee);
            end
          end
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_vld == '0, "R1 rd_vld in reset", int'(rd_vld), 0);
    check(rd_data == '0, "R1 rd_data in reset", int'(rd_data), 0);
    rst = 1'b0;

    // R1: all locks free after reset
    for (int c = 0; c < NC; c++) put_rd(c, mx(c), 1'b0, "R1");
    step();
    for (int c = 0; c < NC; c++) put_rd(c, mx(NM - 1 - c), 1'b0, "R1");
    step();

    // R2: acquire free lock
    put_wr(1, mx(0), 1'b1);
    step();
    check(rd_vld == '0, "R8 no response after write-only cycle", int'(rd_vld), 0);
    put_rd(0, mx(0), 1'b0, "R2 non-owner");
    put_rd(1, mx(0), 1'b1, "R2 owner");
    step();

    // R3: acquire of held lock by other core and by owner
    put_wr(1, mx(0), 1'b1);
    put_wr(2, mx(0), 1'b1);
    step();
    put_rd(1, mx(0), 1'b1, "R3 owner kept");
    put_rd(2, mx(0), 1'b0, "R3 intruder");
    step();

    // R5: release by non-owners ignored
    put_wr(2, mx(0), 1'b0);
    put_wr(3, mx(0), 1'b0);
    step();
    put_rd(1, mx(0), 1'b1, "R5 owner kept");
    step();

    // R4: owner release, then another core acquires
    put_wr(1, mx(0), 1'b0);
    step();
    put_rd(1, mx(0), 1'b0, "R4 released");
    step();
    put_wr(2, mx(0), 1'b1);
    step();
    put_rd(2, mx(0), 1'b1, "R4 reacquired");
    step();
    put_wr(2, mx(0), 1'b0);
    step();

    // R6: three-way contention, then four-way
    put_wr(1, mx(3), 1'b1);
    put_wr(2, mx(3), 1'b1);
    put_wr(3, mx(3), 1'b1);
    step();
    put_rd(1, mx(3), 1'b1, "R6 lowest wins");
    put_rd(2, mx(3), 1'b0, "R6 loser");
    put_rd(3, mx(3), 1'b0, "R6 loser");
    step();
    for (int c = 0; c < NC; c++) put_wr(c, mx(5), 1'b1);
    step();
    put_rd(0, mx(5), 1'b1, "R6 core0 wins");
    put_rd(3, mx(5), 1'b0, "R6 core3 loses");
    step();

    // R7: release and acquire in same cycle leaves lock free
    put_wr(1, mx(3), 1'b0);
    put_wr(2, mx(3), 1'b1);
    step();
    put_rd(1, mx(3), 1'b0, "R7 released");
    put_rd(2, mx(3), 1'b0, "R7 acquire on held fails");
    step();

    // R9: window edges
    put_wr(3, 16'hFC08, 1'b1);
    put_wr(2, 16'hFBFF, 1'b1);
    step();
    put_rd(2, 16'hFBFF, 1'b0, "R9 below window");
    put_rd(3, 16'hFC08, 1'b0, "R9 above window");
    step();
    put_rd(3, mx(0), 1'b0, "R9 no wrap to lock 0");
    step();
    put_wr(3, mx(NM - 1), 1'b1);
    step();
    put_rd(3, mx(NM - 1), 1'b1, "R9 last lock");
    step();

    // R10: independence
    put_wr(3, mx(2), 1'b1);
    step();
    put_wr(3, mx(2), 1'b0);
    step();
    put_rd(3, mx(NM - 1), 1'b1, "R10 other lock kept");
    step();
    put_rd(0, mx(5), 1'b1, "R10 core0 lock kept");
    put_rd(3, mx(2), 1'b0, "R10 freed lock");
    step();

    repeat (3) step();
    check(q_core.size() == 0, "R8 missing responses", q_core.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule